// File: doc/BRIEF.md
# Hot Vector Remapper

This block sits in a storage controller's embedding read path. It counts how often each embedding-vector ID is requested. Every accepted access bumps a per-ID counter held in a small hashed table, and each counter entry carries a tag.

A remap can be started by either of two sources:
- an activity threshold on hot accesses;
- a fixed period of idle cycles.

When a remap starts, the block runs a sequential maximum search over the counter table to pick the K most-accessed IDs in descending order. It gives each picked ID a packed flash location. Consecutive ranks go to successive planes, and each page holds several vectors. The new assignments build up in a shadow table. That table replaces the live table in a single cycle when the remap ends, and the counters are then cleared. Only the hot region is rewritten. Any ID outside the hot set reports a miss, and the read path then uses its default mapping.

The access stream is a valid/ready interface. `acc_ready` drops while a remap is pending or running, and the producer must hold `acc_id` stable with `acc_valid` high until a cycle where both are high. The lookup port never back-pressures: each request cycle produces exactly one response on the next cycle.

Top module: `hot_remap`

## Requirements
- R1: `acc_ready` is high whenever no remap is pending or running, and low from the cycle a remap start is pending until the remap finishes. An access is counted only in a cycle where `acc_valid` and `acc_ready` are both high.
- R2: An access selects the counter entry whose index is the XOR of the ID's 6-bit chunks, taken from bit 0 upward, with the top chunk zero-padded. If the stored tag equals the ID, the count goes up by one and saturates at 255.
- R3: On a tag mismatch, the access takes over the entry (tag set to the ID, count set to 1) only when the entry's count is zero. Otherwise the access is not counted.
- R4: With `thr_en` high, each counted access whose new count is at least `hot_thr` adds one to an activity counter. The remap starts when that counter reaches `act_limit`, so `acc_ready` is low in the cycle after the triggering access.
- R5: With `per_en` high and `period` nonzero, and no other trigger active, `busy` rises exactly `period`+2 cycles after the cycle in which `done` was high.
- R6: The hot-set size K depends on `frac_sel`: 0 gives 5%, 1 gives 10%, and 2 or 3 give 15% of the counter entries, rounded down with a minimum of 1. With 64 entries this is 3, 6 and 9.
- R7: Hot IDs are ranked by descending count, and on equal counts the lower table index ranks first. Entries with a zero count are never selected.
- R8: Rank r is placed at plane r mod 4, page 256 + (r div 4) div 2, and slot (r div 4) mod 2.
- R9: A lookup request produces `lk_rsp_valid` on the next cycle. `lk_hit` is 1 with the ID's plane, page and slot if the ID is in the live hot table. Otherwise `lk_hit` is 0, which means the default mapping applies, and the location fields are 0.
- R10: Lookups made while a remap is running return the previous hot table. At the end of the remap the whole table is replaced, so IDs dropped from the hot set miss from then on.
- R11: `busy` stays high from the cycle after the start through the end of the remap. `done` is high for exactly one cycle at the end, and `busy` is low on the following cycle.
- R12: All counters are zero after a remap, so the next ranking uses only accesses made after it.
- R13: After reset, `busy`, `done` and `lk_rsp_valid` are low, `acc_ready` is high, and no ID hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access stream: ID valid |
| acc_ready | output | 1 | Access stream: block can accept |
| acc_id | input | 16 | Access stream: embedding-vector ID |
| thr_en | input | 1 | Enable the activity-threshold trigger |
| hot_thr | input | 8 | Count at which an access counts as hot activity |
| act_limit | input | 16 | Hot-activity total that starts a remap |
| per_en | input | 1 | Enable the periodic trigger |
| period | input | 16 | Idle cycles between remaps |
| frac_sel | input | 2 | Hot-set fraction select |
| lk_valid | input | 1 | Lookup request valid |
| lk_id | input | 16 | Lookup ID |
| lk_rsp_valid | output | 1 | Lookup response valid |
| lk_hit | output | 1 | ID is in the hot set |
| lk_plane | output | 2 | Remapped plane |
| lk_page | output | 12 | Remapped page |
| lk_slot | output | 1 | Vector slot in page |
| busy | output | 1 | Remap running |
| done | output | 1 | Remap finished (one cycle) |

## Verification
The properties assume the following about the inputs:
- reset is held for at least one clock edge;
- while the period trigger is enabled, `period` is nonzero;
- the producer obeys the valid/ready hold rule.

Under these conditions the response-timing and done/busy properties follow from the block's own sequencing. The directed stimulus is arranged so that every expected result is a single value:
- every hot candidate gets a distinct counter index except one intended collision pair;
- counts are all different, so ranks never depend on the tie rule;
- each timing window is left free of other trigger activity, so the period measurement is exact.

// File: rtl/hot_remap_pkg.sv
`timescale 1ns/1ps
package hot_remap_pkg;
  typedef enum logic [1:0] {SEL_IDLE, SEL_SCAN, SEL_FIN} sel_state_t;

  // hot-set size for a fraction select: 5, 10 or 15 percent, floor, at least 1
  function automatic int unsigned k_of(input logic [1:0] sel, input int unsigned n);
    int unsigned pct;
    int unsigned k;
    case (sel)
      2'd0:    pct = 5;
      2'd1:    pct = 10;
      default: pct = 15;
    endcase
    k = (n * pct) / 100;
    if (k == 0) k = 1;
    return k;
  endfunction
endpackage

// File: rtl/hvr_cnt_table.sv
`timescale 1ns/1ps
module hvr_cnt_table #(
  parameter int ID_W    = 16,
  parameter int ENTRIES = 64,
  parameter int CNT_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       upd_en,
  input  logic [ID_W-1:0]            upd_id,
  input  logic                       clr,
  input  logic [$clog2(ENTRIES)-1:0] rd_idx,
  output logic [ID_W-1:0]            rd_tag,
  output logic [CNT_W-1:0]           rd_cnt,
  output logic                       upd_hit,
  output logic [CNT_W-1:0]           upd_cnt
);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int NCHUNK = (ID_W + IDX_W - 1) / IDX_W;

  logic [ID_W-1:0]  tag_q [ENTRIES];
  logic [CNT_W-1:0] cnt_q [ENTRIES];

  function automatic logic [IDX_W-1:0] fold(input logic [ID_W-1:0] id);
    logic [NCHUNK*IDX_W-1:0] pad;
    logic [IDX_W-1:0] h;
    pad = '0;
    pad[ID_W-1:0] = id;
    h = '0;
    for (int c = 0; c < NCHUNK; c++) h ^= pad[c*IDX_W +: IDX_W];
    return h;
  endfunction

  logic [IDX_W-1:0] idx;
  logic [ID_W-1:0]  cur_tag;
  logic [CNT_W-1:0] cur_cnt;
  logic             match, claim;

  always_comb begin
    idx     = fold(upd_id);
    cur_tag = tag_q[idx];
    cur_cnt = cnt_q[idx];
    match   = (cur_tag == upd_id);
    claim   = !match && (cur_cnt == '0);
    if (match) upd_cnt = (&cur_cnt) ? cur_cnt : cur_cnt + 1'b1;
    else       upd_cnt = {{(CNT_W-1){1'b0}}, 1'b1};
    upd_hit = upd_en && (match || claim);
  end

  assign rd_tag = tag_q[rd_idx];
  assign rd_cnt = cnt_q[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) begin
        tag_q[e] <= '0;
        cnt_q[e] <= '0;
      end
    end else if (clr) begin
      for (int e = 0; e < ENTRIES; e++) cnt_q[e] <= '0;
    end else if (upd_hit) begin
      tag_q[idx] <= upd_id;
      cnt_q[idx] <= upd_cnt;
    end
  end
endmodule

// File: rtl/hvr_trigger.sv
`timescale 1ns/1ps
module hvr_trigger #(
  parameter int CNT_W = 8,
  parameter int ACT_W = 16,
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             upd_hit,
  input  logic [CNT_W-1:0] upd_cnt,
  input  logic             thr_en,
  input  logic [CNT_W-1:0] hot_thr,
  input  logic [ACT_W-1:0] act_limit,
  input  logic             per_en,
  input  logic [PER_W-1:0] period,
  output logic             start
);
  logic [ACT_W-1:0] act_q, act_nx;
  logic [PER_W-1:0] per_q;
  logic             idle, act_inc, thr_fire, per_fire;

  always_comb begin
    idle     = !busy && !start;
    act_inc  = upd_hit && (upd_cnt >= hot_thr);
    act_nx   = act_q + ACT_W'(act_inc);
    thr_fire = thr_en && act_inc && (act_nx >= act_limit);
    per_fire = per_en && (period != '0) && (per_q == period - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= '0;
      per_q <= '0;
      start <= 1'b0;
    end else if (start) begin
      act_q <= '0;
      per_q <= '0;
      start <= 1'b0;
    end else if (idle) begin
      start <= thr_fire || per_fire;
      act_q <= act_nx;
      per_q <= per_fire ? '0 : per_q + 1'b1;
    end
  end
endmodule

// File: rtl/hvr_topk.sv
`timescale 1ns/1ps
module hvr_topk
  import hot_remap_pkg::*;
#(
  parameter int ID_W    = 16,
  parameter int ENTRIES = 64,
  parameter int CNT_W   = 8,
  parameter int KMAX    = 9,
  parameter int RANK_W  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [1:0]                 frac_sel,
  input  logic [ID_W-1:0]            rd_tag,
  input  logic [CNT_W-1:0]           rd_cnt,
  output logic [$clog2(ENTRIES)-1:0] rd_idx,
  output logic                       busy,
  output logic                       done,
  output logic                       wr_en,
  output logic [RANK_W-1:0]          wr_rank,
  output logic [ID_W-1:0]            wr_id
);
  localparam int IDX_W = $clog2(ENTRIES);

  sel_state_t         st_q;
  logic [RANK_W-1:0]  k_q, r_q;
  logic [IDX_W-1:0]   i_q;
  logic [CNT_W-1:0]   best_cnt, cand_cnt;
  logic [IDX_W-1:0]   best_idx, cand_idx;
  logic [ID_W-1:0]    best_tag, cand_tag;
  logic [ENTRIES-1:0] picked_q;
  logic               take, last, found;

  always_comb begin
    take     = (st_q == SEL_SCAN) && !picked_q[i_q] && (rd_cnt > best_cnt);
    cand_cnt = take ? rd_cnt : best_cnt;
    cand_idx = take ? i_q    : best_idx;
    cand_tag = take ? rd_tag : best_tag;
    last     = (i_q == IDX_W'(ENTRIES - 1));
    found    = (cand_cnt != '0);
    wr_en    = (st_q == SEL_SCAN) && last && found;
    wr_rank  = r_q;
    wr_id    = cand_tag;
  end

  assign rd_idx = i_q;
  assign busy   = (st_q != SEL_IDLE);
  assign done   = (st_q == SEL_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= SEL_IDLE;
      k_q      <= '0;
      r_q      <= '0;
      i_q      <= '0;
      best_cnt <= '0;
      best_idx <= '0;
      best_tag <= '0;
      picked_q <= '0;
    end else begin
      case (st_q)
        SEL_IDLE: if (start) begin
          st_q     <= SEL_SCAN;
          k_q      <= RANK_W'(k_of(frac_sel, ENTRIES));
          r_q      <= '0;
          i_q      <= '0;
          best_cnt <= '0;
          picked_q <= '0;
        end
        SEL_SCAN: begin
          best_cnt <= cand_cnt;
          best_idx <= cand_idx;
          best_tag <= cand_tag;
          i_q      <= i_q + 1'b1;
          if (last) begin
            i_q      <= '0;
            best_cnt <= '0;
            if (found) picked_q[cand_idx] <= 1'b1;
            if (!found || r_q == k_q - 1'b1) st_q <= SEL_FIN;
            else r_q <= r_q + 1'b1;
          end
        end
        default: st_q <= SEL_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hvr_remap_tbl.sv
`timescale 1ns/1ps
module hvr_remap_tbl #(
  parameter int ID_W     = 16,
  parameter int KMAX     = 9,
  parameter int RANK_W   = 4,
  parameter int PLANES   = 4,
  parameter int VPP      = 2,
  parameter int PAGE_W   = 12,
  parameter int HOT_BASE = 256,
  parameter int PL_W     = 2,
  parameter int SL_W     = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shadow_clr,
  input  logic              wr_en,
  input  logic [RANK_W-1:0] wr_rank,
  input  logic [ID_W-1:0]   wr_id,
  input  logic              commit,
  input  logic              lk_valid,
  input  logic [ID_W-1:0]   lk_id,
  output logic              lk_rsp_valid,
  output logic              lk_hit,
  output logic [PL_W-1:0]   lk_plane,
  output logic [PAGE_W-1:0] lk_page,
  output logic [SL_W-1:0]   lk_slot
);
  logic [KMAX-1:0] sh_v, act_v, match;
  logic [ID_W-1:0] sh_id  [KMAX];
  logic [ID_W-1:0] act_id [KMAX];

  for (genvar g = 0; g < KMAX; g++) begin : g_cmp
    assign match[g] = act_v[g] && (act_id[g] == lk_id);
  end

  logic              hit_n;
  logic [RANK_W-1:0] hit_rank;
  logic [31:0]       grp;
  logic [PL_W-1:0]   plane_n;
  logic [PAGE_W-1:0] page_n;
  logic [SL_W-1:0]   slot_n;

  always_comb begin
    hit_n    = |match;
    hit_rank = '0;
    for (int r = 0; r < KMAX; r++) if (match[r]) hit_rank = RANK_W'(r);
    grp     = 32'(hit_rank) / PLANES;
    plane_n = PL_W'(32'(hit_rank) % PLANES);
    page_n  = PAGE_W'(HOT_BASE + grp / VPP);
    slot_n  = SL_W'(grp % VPP);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_v  <= '0;
      act_v <= '0;
      for (int r = 0; r < KMAX; r++) begin
        sh_id[r]  <= '0;
        act_id[r] <= '0;
      end
      lk_rsp_valid <= 1'b0;
      lk_hit       <= 1'b0;
      lk_plane     <= '0;
      lk_page      <= '0;
      lk_slot      <= '0;
    end else begin
      if (shadow_clr) sh_v <= '0;
      else if (wr_en) begin
        sh_v[wr_rank]  <= 1'b1;
        sh_id[wr_rank] <= wr_id;
      end
      if (commit) begin
        act_v <= sh_v;
        for (int r = 0; r < KMAX; r++) act_id[r] <= sh_id[r];
      end
      lk_rsp_valid <= lk_valid;
      lk_hit       <= lk_valid && hit_n;
      lk_plane     <= (lk_valid && hit_n) ? plane_n : '0;
      lk_page      <= (lk_valid && hit_n) ? page_n  : '0;
      lk_slot      <= (lk_valid && hit_n) ? slot_n  : '0;
    end
  end
endmodule

// File: rtl/hot_remap.sv
`timescale 1ns/1ps
module hot_remap
  import hot_remap_pkg::*;
#(
  parameter int ID_W     = 16,
  parameter int ENTRIES  = 64,
  parameter int CNT_W    = 8,
  parameter int PLANES   = 4,
  parameter int VPP      = 2,
  parameter int PAGE_W   = 12,
  parameter int HOT_BASE = 256,
  parameter int ACT_W    = 16,
  parameter int PER_W    = 16,
  localparam int KMAX    = k_of(2'd2, ENTRIES),
  localparam int RANK_W  = $clog2(KMAX + 1),
  localparam int PL_W    = (PLANES > 1) ? $clog2(PLANES) : 1,
  localparam int SL_W    = (VPP > 1) ? $clog2(VPP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [ID_W-1:0]   acc_id,
  input  logic              thr_en,
  input  logic [CNT_W-1:0]  hot_thr,
  input  logic [ACT_W-1:0]  act_limit,
  input  logic              per_en,
  input  logic [PER_W-1:0]  period,
  input  logic [1:0]        frac_sel,
  input  logic              lk_valid,
  input  logic [ID_W-1:0]   lk_id,
  output logic              lk_rsp_valid,
  output logic              lk_hit,
  output logic [PL_W-1:0]   lk_plane,
  output logic [PAGE_W-1:0] lk_page,
  output logic [SL_W-1:0]   lk_slot,
  output logic              busy,
  output logic              done
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic              start, upd_hit, wr_en;
  logic [CNT_W-1:0]  upd_cnt, rd_cnt;
  logic [ID_W-1:0]   rd_tag, wr_id;
  logic [IDX_W-1:0]  rd_idx;
  logic [RANK_W-1:0] wr_rank;

  assign acc_ready = !busy && !start;

  hvr_cnt_table #(.ID_W(ID_W), .ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .upd_en(acc_valid && acc_ready), .upd_id(acc_id),
    .clr(done), .rd_idx(rd_idx), .rd_tag(rd_tag), .rd_cnt(rd_cnt),
    .upd_hit(upd_hit), .upd_cnt(upd_cnt));

  hvr_trigger #(.CNT_W(CNT_W), .ACT_W(ACT_W), .PER_W(PER_W)) u_trig (
    .clk(clk), .rst_n(rst_n), .busy(busy), .upd_hit(upd_hit), .upd_cnt(upd_cnt),
    .thr_en(thr_en), .hot_thr(hot_thr), .act_limit(act_limit),
    .per_en(per_en), .period(period), .start(start));

  hvr_topk #(.ID_W(ID_W), .ENTRIES(ENTRIES), .CNT_W(CNT_W), .KMAX(KMAX),
             .RANK_W(RANK_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .start(start), .frac_sel(frac_sel),
    .rd_tag(rd_tag), .rd_cnt(rd_cnt), .rd_idx(rd_idx), .busy(busy), .done(done),
    .wr_en(wr_en), .wr_rank(wr_rank), .wr_id(wr_id));

  hvr_remap_tbl #(.ID_W(ID_W), .KMAX(KMAX), .RANK_W(RANK_W), .PLANES(PLANES),
                  .VPP(VPP), .PAGE_W(PAGE_W), .HOT_BASE(HOT_BASE),
                  .PL_W(PL_W), .SL_W(SL_W)) u_map (
    .clk(clk), .rst_n(rst_n), .shadow_clr(start), .wr_en(wr_en), .wr_rank(wr_rank),
    .wr_id(wr_id), .commit(done), .lk_valid(lk_valid), .lk_id(lk_id),
    .lk_rsp_valid(lk_rsp_valid), .lk_hit(lk_hit), .lk_plane(lk_plane),
    .lk_page(lk_page), .lk_slot(lk_slot));
endmodule

// File: rtl/hot_remap_chk.sv
`timescale 1ns/1ps
module hot_remap_chk #(
  parameter int VPP      = 2,
  parameter int HOT_BASE = 256,
  parameter int PAGE_W   = 12,
  parameter int SL_W     = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_ready,
  input logic              lk_valid,
  input logic              lk_rsp_valid,
  input logic              lk_hit,
  input logic [PAGE_W-1:0] lk_page,
  input logic [SL_W-1:0]   lk_slot,
  input logic              busy,
  input logic              done
);
  // R1
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !acc_ready);
  // R9
  rsp_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> lk_rsp_valid);
  // R9
  hit_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_rsp_valid |-> !lk_hit);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  // R11
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));
  // R8
  loc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (32'(lk_slot) < VPP && 32'(lk_page) >= HOT_BASE));
endmodule

bind hot_remap hot_remap_chk #(.VPP(VPP), .HOT_BASE(HOT_BASE), .PAGE_W(PAGE_W),
                               .SL_W(SL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_ready(acc_ready), .lk_valid(lk_valid),
  .lk_rsp_valid(lk_rsp_valid), .lk_hit(lk_hit), .lk_page(lk_page),
  .lk_slot(lk_slot), .busy(busy), .done(done));

// File: tb/sim_hot_remap.sv
`timescale 1ns/1ps
module sim_hot_remap;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_ready;
  logic [15:0] acc_id = '0;
  logic        thr_en = 1'b0;
  logic [7:0]  hot_thr = '0;
  logic [15:0] act_limit = '0;
  logic        per_en = 1'b0;
  logic [15:0] period = '0;
  logic [1:0]  frac_sel = '0;
  logic        lk_valid = 1'b0;
  logic [15:0] lk_id = '0;
  logic        lk_rsp_valid, lk_hit, busy, done;
  logic [1:0]  lk_plane;
  logic [11:0] lk_page;
  logic [0:0]  lk_slot;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int cyc_done = 0;
  int cyc_busy = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hot_remap u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_id(acc_id), .thr_en(thr_en), .hot_thr(hot_thr), .act_limit(act_limit),
    .per_en(per_en), .period(period), .frac_sel(frac_sel), .lk_valid(lk_valid),
    .lk_id(lk_id), .lk_rsp_valid(lk_rsp_valid), .lk_hit(lk_hit),
    .lk_plane(lk_plane), .lk_page(lk_page), .lk_slot(lk_slot),
    .busy(busy), .done(done));

  // {id, access count, expect hit, expected rank}; the first remap uses K=9
  localparam int NV = 10;
  localparam logic [28:0] TBL [NV] = '{
    {16'h0011, 8'd13, 1'b1, 4'd1}, {16'h0012, 8'd12, 1'b1, 4'd2},
    {16'h0013, 8'd11, 1'b1, 4'd3}, {16'h0014, 8'd10, 1'b1, 4'd4},
    {16'h0015, 8'd9,  1'b1, 4'd5}, {16'h0016, 8'd8,  1'b1, 4'd6},
    {16'h0017, 8'd7,  1'b1, 4'd7}, {16'h0018, 8'd6,  1'b1, 4'd8},
    {16'h0019, 8'd5,  1'b0, 4'd0}, {16'h0010, 8'd14, 1'b1, 4'd0}};

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] id);
    acc_id = id;
    acc_valid = 1'b1;
    while (!acc_ready) @(negedge clk);
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic look(input logic [15:0] id, input bit exp_hit, input int rank,
                      input string req);
    int ep, eg, es, act_loc, exp_loc;
    lk_id = id;
    lk_valid = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0;
    ep = exp_hit ? rank % 4 : 0;
    eg = exp_hit ? 256 + (rank / 4) / 2 : 0;
    es = exp_hit ? (rank / 4) % 2 : 0;
    act_loc = {int'(lk_rsp_valid), int'(lk_hit), int'(lk_plane), int'(lk_page), int'(lk_slot)};
    exp_loc = {1, int'(exp_hit), ep, eg, es};
    check(lk_rsp_valid == 1'b1 && lk_hit == exp_hit && lk_plane == ep[1:0] &&
          lk_page == eg[11:0] && lk_slot == es[0:0], req,
          $sformatf("lookup %h {vld,hit,plane,page,slot}", id),
          {int'(lk_rsp_valid), int'(lk_hit), int'(lk_plane), int'(lk_slot)},
          {1, int'(exp_hit), ep, es});
    if (exp_hit && lk_page != eg[11:0])
      $display("   page actual=%0d expected=%0d", lk_page, eg);
    if (act_loc == exp_loc) begin end
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    cyc_done = cyc;
    @(negedge clk);
    check(!done && !busy, "R11", "done width / busy after done",
          {int'(done), int'(busy)}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    check(!busy && !done && acc_ready && !lk_rsp_valid, "R13", "reset outputs",
          {int'(busy), int'(done), int'(acc_ready), int'(lk_rsp_valid)}, 2);
    look(16'h0010, 1'b0, 0, "R9");

    // first remap: threshold trigger, K=9
    thr_en = 1'b1; hot_thr = 8'd14; act_limit = 16'd1; frac_sel = 2'd2;
    for (int v = 0; v < NV; v++)
      for (int n = 0; n < int'(TBL[v][12:5]); n++) send(TBL[v][28:13]);
    // R4 / R1: start pending right after the triggering access
    check(acc_ready == 1'b0, "R4", "acc_ready after threshold hit", int'(acc_ready), 0);
    thr_en = 1'b0; per_en = 1'b1; period = 16'd40;
    @(negedge clk);
    check(busy && !acc_ready, "R1", "busy with ready low",
          {int'(busy), int'(acc_ready)}, 2);
    wait_done();
    frac_sel = 2'd0;
    // R7 R8 R6: ranking, placement, 9-entry cut
    for (int v = 0; v < NV; v++)
      look(TBL[v][28:13], TBL[v][4], int'(TBL[v][3:0]), TBL[v][4] ? "R7/R8" : "R6");

    // second remap: period trigger, K=3
    repeat (3) send(16'h0020);
    send(16'h0021);
    check(busy == 1'b0, "R5", "no early period trigger", int'(busy), 0);
    while (!busy) @(negedge clk);
    cyc_busy = cyc;
    check(cyc_busy - cyc_done == 42, "R5", "period start delay",
          cyc_busy - cyc_done, 42);
    // R10: old table visible during remap
    look(16'h0010, 1'b1, 0, "R10");
    look(16'h0018, 1'b1, 8, "R10");
    period = 16'd2000;
    wait_done();
    look(16'h0010, 1'b0, 0, "R12");
    look(16'h0020, 1'b1, 0, "R8");
    look(16'h0021, 1'b1, 1, "R8");
    look(16'h0012, 1'b0, 0, "R10");

    // third remap: saturation and tag collision
    repeat (200) send(16'h0031);
    repeat (266) send(16'h0030);
    repeat (3) send(16'h0005);
    repeat (5) send(16'h1045);
    wait_done();
    look(16'h0030, 1'b1, 0, "R2");
    look(16'h0031, 1'b1, 1, "R2");
    look(16'h0005, 1'b1, 2, "R3");
    look(16'h1045, 1'b0, 0, "R3");
    look(16'h0020, 1'b0, 0, "R12");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule